// File: doc/BRIEF.md
# Dual-Channel DDR ADC Lane Deserializer

This block sits behind the receive pins of a two-channel converter. Each channel presents a 14-bit sample on seven lanes, and each lane carries two bits per converter clock, one in each half-cycle. The block captures every lane once per edge of a fast serial clock that runs at twice the converter clock. It groups four consecutive captures into one frame and rebuilds two samples per channel from each frame: an odd one from the first half of the frame and an even one from the second half.

The samples are then turned into output words. Each sample has the lane polarity swap undone, its offset-binary code converted to two's complement, and is left-justified into a wider word with zero padding below it. A phase select picks the even or odd sample, which halves the sample rate. A channel select picks A or B. The chosen word is registered once per frame, so the output behaves as if it ran on a parallel clock at one quarter of the serial rate. The parameter `SWAP_PAIRS` describes an interconnect that swaps P and N of every pair. With it set, the block captures on the falling serial edge and complements every lane bit.

Top module: `ddr_adc_deser`

## Requirements
- R1: A synchronous reset clears the frame position, the lane history, the parallel words and the output. While reset is applied and afterwards, `data_out` is 0 and `out_valid` is 0 until R10 allows otherwise.
- R2: With `SWAP_PAIRS`=1, lanes are captured on the falling edge of `clk_ser` and all state changes on that edge. With `SWAP_PAIRS`=0 the rising edge is used.
- R3: With `SWAP_PAIRS`=1, every captured lane bit is complemented before use. A raw level of 0 counts as a logic 1.
- R4: After reset, each run of four consecutive captures t0, t1, t2, t3 forms one frame. The odd sample is built from t0 and t1, and the even sample from t2 and t3.
- R5: Within a pair, lane k supplies two bits of the 14-bit sample. The earlier capture goes to bit 2k and the later capture to bit 2k+1, so lane 6 carries bits 13 and 12.
- R6: Bit 13 of the rebuilt sample is inverted, which converts offset binary to two's complement.
- R7: The 14-bit result occupies `data_out[15:2]`, and `data_out[1:0]` is always 0.
- R8: `sel_odd`=0 forwards the even sample and `sel_odd`=1 forwards the odd sample. `sel_chb`=0 forwards channel A and `sel_chb`=1 forwards channel B.
- R9: `data_out` changes only on the capture edge that completes a frame. It then shows the word built from the frame completed one frame earlier.
- R10: `out_valid` rises on the capture edge that completes the second frame after reset and stays high until the next reset. While it is low, `data_out` is 0.
- R11: `sel_odd` and `sel_chb` are looked at only on the capture edge that completes a frame. Changing them at other times and restoring them before that edge has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ser | input | 1 | Serial capture clock, twice the converter clock |
| rst | input | 1 | Synchronous reset, active high |
| lanes_a | input | LANES | Channel A lane levels |
| lanes_b | input | LANES | Channel B lane levels |
| sel_odd | input | 1 | 0 selects the even sample, 1 selects the odd sample |
| sel_chb | input | 1 | 0 selects channel A, 1 selects channel B |
| data_out | output | OUT_W | Signed, left-justified selected sample |
| out_valid | output | 1 | High once a complete frame has reached the output |

## Verification
The bench builds the block with its defaults: seven lanes, a 16-bit output and swapped pairs. These values bring the falling-edge capture, the complemented lanes and the two pad bits within reach.

On every serial cycle, the bench changes the lanes to a complemented garbage value shortly after the falling edge and restores the real value after the rising edge. A design that captured on the wrong edge would therefore take the garbage.

Directed frames place single bits at chosen lanes and time slots, to pin down the pair ordering and the even/odd split. Selects are toggled inside a frame to show they are ignored there. The behavioural model then tracks random frames, random select settings and a reset in mid-run.

// File: rtl/ddr_adc_deser.sv
module ddr_adc_deser #(
  parameter int LANES      = 7,
  parameter int OUT_W      = 16,
  parameter bit SWAP_PAIRS = 1'b1
) (
  input  logic             clk_ser,
  input  logic             rst,
  input  logic [LANES-1:0] lanes_a,
  input  logic [LANES-1:0] lanes_b,
  input  logic             sel_odd,
  input  logic             sel_chb,
  output logic [OUT_W-1:0] data_out,
  output logic             out_valid
);
  localparam int SW  = 2 * LANES;
  localparam int PAD = OUT_W - SW;

  logic             cap_clk;
  logic [LANES-1:0] bit_a, bit_b;
  logic [LANES-1:0] hist_a [3];
  logic [LANES-1:0] hist_b [3];
  logic [1:0]       phase;
  logic             frame_end;
  logic             pw_full;
  logic [SW-1:0]    even_a, odd_a, even_b, odd_b;
  logic [SW-1:0]    pw_ev_a, pw_od_a, pw_ev_b, pw_od_b;
  logic [SW-1:0]    pick;
  logic [OUT_W-1:0] word;

  assign cap_clk   = SWAP_PAIRS ? ~clk_ser : clk_ser;
  assign bit_a     = SWAP_PAIRS ? ~lanes_a : lanes_a;
  assign bit_b     = SWAP_PAIRS ? ~lanes_b : lanes_b;
  assign frame_end = (phase == 2'd3);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign even_a[2*k]   = hist_a[0][k];
    assign even_a[2*k+1] = bit_a[k];
    assign odd_a[2*k]    = hist_a[2][k];
    assign odd_a[2*k+1]  = hist_a[1][k];
    assign even_b[2*k]   = hist_b[0][k];
    assign even_b[2*k+1] = bit_b[k];
    assign odd_b[2*k]    = hist_b[2][k];
    assign odd_b[2*k+1]  = hist_b[1][k];
  end

  assign pick = sel_chb ? (sel_odd ? pw_od_b : pw_ev_b)
                        : (sel_odd ? pw_od_a : pw_ev_a);
  assign word = OUT_W'({~pick[SW-1], pick[SW-2:0]}) << PAD;

  always_ff @(posedge cap_clk) begin
    if (rst) begin
      phase     <= '0;
      pw_full   <= 1'b0;
      out_valid <= 1'b0;
      data_out  <= '0;
      pw_ev_a   <= '0;
      pw_od_a   <= '0;
      pw_ev_b   <= '0;
      pw_od_b   <= '0;
      for (int i = 0; i < 3; i++) begin
        hist_a[i] <= '0;
        hist_b[i] <= '0;
      end
    end else begin
      phase     <= phase + 2'd1;
      hist_a[0] <= bit_a;
      hist_a[1] <= hist_a[0];
      hist_a[2] <= hist_a[1];
      hist_b[0] <= bit_b;
      hist_b[1] <= hist_b[0];
      hist_b[2] <= hist_b[1];
      if (frame_end) begin
        pw_ev_a <= even_a;
        pw_od_a <= odd_a;
        pw_ev_b <= even_b;
        pw_od_b <= odd_b;
        pw_full <= 1'b1;
        if (pw_full) begin
          data_out  <= word;
          out_valid <= 1'b1;
        end
      end
    end
  end

  assert_hold_between_frames_R9: assert property (@(posedge cap_clk) disable iff (rst)
    (phase != 2'd3) |=> $stable(data_out));

  assert_valid_sticky_R10: assert property (@(posedge cap_clk) disable iff (rst)
    out_valid |=> out_valid);

  assert_idle_output_zero_R10: assert property (@(posedge cap_clk) disable iff (rst)
    !out_valid |-> (data_out == '0));

  assert_valid_rises_at_frame_R10: assert property (@(posedge cap_clk) disable iff (rst)
    $rose(out_valid) |-> ($past(phase) == 2'd3));
endmodule

// File: tb/ddr_adc_deser_tb_top.sv
`timescale 1ns/1ps
module ddr_adc_deser_tb_top;
  localparam int L = 7;
  localparam int W = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst = 1'b1;
  logic [L-1:0] la = '0, lb = '0;
  logic         so = 1'b0, sc = 1'b0;
  wire  [W-1:0] dout;
  wire          val;

  ddr_adc_deser #(.LANES(L), .OUT_W(W), .SWAP_PAIRS(1'b1)) dut_i (
    .clk_ser(clk), .rst(rst), .lanes_a(la), .lanes_b(lb),
    .sel_odd(so), .sel_chb(sc), .data_out(dout), .out_valid(val));

  int errs = 0, checks = 0;
  bit finished = 0;

  // behavioural reference
  int            ncap = 0;
  bit            armed = 0, have = 0;
  logic [L-1:0]  fa [4];
  logic [L-1:0]  fb [4];
  logic [13:0]   ev_a, od_a, ev_b, od_b;
  logic [W-1:0]  exp_out = '0;
  logic          exp_val = 1'b0;

  function automatic logic [W-1:0] fmt(input logic [13:0] s);
    return {~s[13], s[12:0], 2'b00};
  endfunction

  function automatic logic [13:0] rebuild(input logic [L-1:0] early, input logic [L-1:0] late);
    logic [13:0] s;
    for (int k = 0; k < L; k++) begin
      s[2*k]   = early[k];
      s[2*k+1] = late[k];
    end
    return s;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model(input logic r, input logic [L-1:0] a, input logic [L-1:0] b,
                       input logic o, input logic c);
    logic [13:0] p;
    if (r) begin
      ncap = 0; have = 0; exp_out = '0; exp_val = 1'b0; armed = 1;
    end else begin
      fa[ncap % 4] = ~a;
      fb[ncap % 4] = ~b;
      ncap++;
      if (ncap % 4 == 0) begin
        if (have) begin
          p = c ? (o ? od_b : ev_b) : (o ? od_a : ev_a);
          exp_out = fmt(p);
          exp_val = 1'b1;
        end
        ev_a = rebuild(fa[2], fa[3]);
        od_a = rebuild(fa[0], fa[1]);
        ev_b = rebuild(fb[2], fb[3]);
        od_b = rebuild(fb[0], fb[1]);
        have = 1;
      end
    end
  endtask

  // real data held across the falling edge; complemented garbage across the rising edge (R2)
  task automatic step(input logic [L-1:0] a, input logic [L-1:0] b,
                      input logic r, input logic o, input logic c);
    @(posedge clk); #1;
    rst = r; la = a; lb = b; so = o; sc = c;
    @(negedge clk); #1;
    model(r, a, b, o, c);
    if (armed) begin
      chk("R2 R9 word", dout, exp_out);
      chk("R10 valid", val, exp_val);
    end
    la = ~a; lb = ~b;
  endtask

  task automatic frame(input logic [3:0][L-1:0] a, input logic [3:0][L-1:0] b,
                       input logic o, input logic c);
    for (int i = 0; i < 4; i++) step(a[i], b[i], 1'b0, o, c);
  endtask

  logic [3:0][L-1:0] xa, xb, ya, yb, ra, rb;

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) step('0, '0, 1'b1, 1'b0, 1'b0);
    chk("R1 reset data", dout, 16'h0000);
    chk("R1 reset valid", val, 1'b0);

    for (int i = 0; i < 4; i++) begin
      xa[i] = '0; xb[i] = '1;
      ya[i] = '1; yb[i] = '1;
    end
    ya[0] = ~7'h40; ya[3] = ~7'h01; yb[2] = ~7'h20;

    frame(xa, xb, 1'b0, 1'b0);
    chk("R10 not valid after first frame", val, 1'b0);
    frame(ya, yb, 1'b0, 1'b0);
    chk("R3 R6 R7 all-ones even A", dout, 16'h7FFC);
    chk("R10 valid after second frame", val, 1'b1);
    frame(ya, yb, 1'b0, 1'b0);
    chk("R4 R5 even A lane0 late bit", dout, 16'h8008);
    frame(ya, yb, 1'b1, 1'b0);
    chk("R8 R4 odd A lane6 early bit", dout, 16'hC000);
    frame(ya, yb, 1'b0, 1'b1);
    chk("R8 even B lane5", dout, 16'h9000);
    frame(ya, yb, 1'b1, 1'b1);
    chk("R8 odd B", dout, 16'h8000);

    // R11: selects wiggled mid-frame, restored before the frame edge
    step(ya[0], yb[0], 1'b0, 1'b0, 1'b1);
    step(ya[1], yb[1], 1'b0, 1'b1, 1'b0);
    step(ya[2], yb[2], 1'b0, 1'b0, 1'b1);
    chk("R11 R9 output held mid-frame", dout, 16'h8000);
    step(ya[3], yb[3], 1'b0, 1'b0, 1'b0);
    chk("R11 select taken at frame edge", dout, 16'h8008);

    for (int f = 0; f < 40; f++) begin
      for (int i = 0; i < 4; i++) begin
        ra[i] = L'($urandom); rb[i] = L'($urandom);
      end
      frame(ra, rb, 1'($urandom), 1'($urandom));
    end

    step('0, '0, 1'b1, 1'b0, 1'b0);
    step('0, '0, 1'b1, 1'b0, 1'b0);
    chk("R1 mid-run reset data", dout, 16'h0000);
    chk("R1 mid-run reset valid", val, 1'b0);
    frame(xa, xb, 1'b0, 1'b0);
    chk("R10 invalid one frame after reset", val, 1'b0);
    frame(xa, xb, 1'b0, 1'b0);
    chk("R3 R7 word after reset", dout, 16'h7FFC);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule